// File: doc/BRIEF.md
# Three-Phase Header-Aligned Serial Word Receiver

This block receives result words from a converter whose serial data line carries no clock of its own. The host issues a burst of bit periods on a shared clock. Because the line's delay is not known to the host, the receiver runs on a clock three times faster than the bit rate. It takes three copies of the line per bit period, one at each of three evenly spaced offsets, and so builds three sample streams for every frame.

Every frame starts with a three-bit marker of zero, one, zero, followed by sixteen data bits sent most significant first. When the frame ends, the receiver tests the marker in each stream. Where several streams carry it intact it picks the one in the middle of those, which leaves the most timing margin on either side. It then delivers that stream's sixteen data bits with a one-cycle strobe. When no stream carries the marker, it raises a one-cycle error pulse and delivers no word. One instance is meant for each converter, so converters with different line delays can share one burst clock.

Top module: `capture_rx`

## Requirements
- R1: While `rstN` is low, `wordValid` and `frameErr` are 0, and `wordOut` and `phaseSel` are 0.
- R2: A frame begins at the rising edge where `startIn` is 1 while no frame is in progress. Counting that edge as edge 0, the line value present at edge 1+3j+p is sample j of phase p, for j from 0 to 18 and p from 0 to 2.
- R3: A phase carries a good marker exactly when its samples 0, 1 and 2 are 0, 1 and 0 in that order.
- R4: The delivered word is samples 3 to 18 of the chosen phase, with sample 3 as bit 15 and sample 18 as bit 0. `phaseSel` gives the chosen phase number as 0, 1 or 2.
- R5: If all three phases are good, phase 1 is chosen. If exactly two are good, the later one in the circular order 0→1→2→0 is chosen, so {0,1} gives 1, {1,2} gives 2 and {2,0} gives 0. If only one is good, that phase is chosen.
- R6: If no phase is good, `frameErr` pulses for one cycle, `wordValid` stays 0, and `wordOut` and `phaseSel` keep their previous values.
- R7: Each frame produces exactly one one-cycle pulse, either on `wordValid` or on `frameErr`. The pulse goes high at edge 58 and low at edge 59.
- R8: A high `startIn` during a frame (edges 1 to 57) has no effect. It changes neither the current frame's result nor its timing, and it produces no extra result afterwards.
- R9: `wordOut` and `phaseSel` change only when `wordValid` pulses, and otherwise hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, three cycles per bit period |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Begins a frame when idle |
| dataIn | input | 1 | Serial data line from the converter |
| wordOut | output | DATA_W | Last captured data word |
| wordValid | output | 1 | One-cycle strobe for a new word |
| frameErr | output | 1 | One-cycle strobe when no phase has a good marker |
| phaseSel | output | 2 | Phase the last word was taken from |

## Verification
The bench builds the receiver with its default parameters: 16 data bits and a three-bit marker of 0-1-0, which gives 19 samples per phase and a result at edge 58. Because each phase samples its own clock cycles, the bench writes each phase's stream on its own. That lets it produce every one of the eight good/bad marker combinations, and it places a different word on each phase so that choosing the wrong phase shows up in the output. Random frames add corrupted markers, including ones that happen to match, and a directed frame sends a start pulse in the middle of a frame.

// File: rtl/capture_pkg.sv
package capture_pkg;
  localparam int NUM_PH = 3;

  typedef struct packed {
    logic              clear;
    logic [NUM_PH-1:0] sampleEn;
    logic              decide;
  } capStrobes_t;
endpackage

// File: rtl/phase_pick.sv
module phase_pick (
  input  logic [2:0] validMask,
  output logic [1:0] pickIdx,
  output logic       anyValid
);
  // Middle of the good phases; with two good phases, the later one in circular order.
  always_comb begin
    anyValid = 1'b1;
    pickIdx  = 2'd0;
    case (validMask)
      3'b111: pickIdx = 2'd1;
      3'b011: pickIdx = 2'd1;
      3'b110: pickIdx = 2'd2;
      3'b101: pickIdx = 2'd0;
      3'b001: pickIdx = 2'd0;
      3'b010: pickIdx = 2'd1;
      3'b100: pickIdx = 2'd2;
      default: begin
        anyValid = 1'b0;
        pickIdx  = 2'd0;
      end
    endcase
  end
endmodule

// File: rtl/capture_ctl.sv
module capture_ctl
  import capture_pkg::*;
#(
  parameter int FRAME_LEN = 19
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  output capStrobes_t strobes
);
  localparam int SLOT_W = $clog2(FRAME_LEN);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);
  localparam logic [1:0] LAST_PH = 2'(NUM_PH - 1);

  logic              busy;
  logic [1:0]        phaseCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic              doneQ;
  logic              lastSample;

  assign lastSample = busy && (phaseCnt == LAST_PH) && (slotCnt == LAST_SLOT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      phaseCnt <= 2'd0;
      slotCnt  <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= lastSample;
      if (!busy) begin
        if (startIn) begin
          busy     <= 1'b1;
          phaseCnt <= 2'd0;
          slotCnt  <= '0;
        end
      end else if (phaseCnt == LAST_PH) begin
        phaseCnt <= 2'd0;
        slotCnt  <= slotCnt + 1'b1;
        if (lastSample) busy <= 1'b0;
      end else begin
        phaseCnt <= phaseCnt + 2'd1;
      end
    end
  end

  always_comb begin
    strobes.clear  = !busy && startIn;
    strobes.decide = doneQ;
  end

  for (genvar p = 0; p < NUM_PH; p++) begin : g_en
    assign strobes.sampleEn[p] = busy && (phaseCnt == 2'(p));
  end

  // R8: a start seen mid-frame does not restart the phase count
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startIn && phaseCnt != LAST_PH) |=> (busy && phaseCnt == $past(phaseCnt) + 2'd1));
  // R7: the decision strobe lasts a single cycle
  a_r7_single_decide: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  // R2: the slot count never passes the frame length
  a_r2_slot_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (slotCnt <= LAST_SLOT));
  // R2: no more than one phase samples in any cycle
  a_r2_one_phase: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.sampleEn));
endmodule

// File: rtl/capture_dp.sv
module capture_dp
  import capture_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HDR_W  = 3,
  parameter logic [HDR_W-1:0] HDR_PAT = 3'b010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataIn,
  input  capStrobes_t       strobes,
  output logic [DATA_W-1:0] wordOut,
  output logic              wordValid,
  output logic              frameErr,
  output logic [1:0]        phaseSel
);
  localparam int FRAME_LEN = HDR_W + DATA_W;

  logic [FRAME_LEN-1:0] frames [NUM_PH];
  logic [NUM_PH-1:0]    hdrOk;
  logic [1:0]           pickIdx;
  logic                 anyValid;
  logic [DATA_W-1:0]    chosenWord;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
    logic [FRAME_LEN-1:0] sr;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   sr <= '0;
      else if (strobes.clear)      sr <= '0;
      else if (strobes.sampleEn[p]) sr <= {sr[FRAME_LEN-2:0], dataIn};
    end
    assign frames[p] = sr;
    assign hdrOk[p]  = (sr[FRAME_LEN-1 -: HDR_W] == HDR_PAT);
  end

  phase_pick u_pick (
    .validMask(hdrOk),
    .pickIdx  (pickIdx),
    .anyValid (anyValid)
  );

  always_comb begin
    case (pickIdx)
      2'd1:    chosenWord = frames[1][DATA_W-1:0];
      2'd2:    chosenWord = frames[2][DATA_W-1:0];
      default: chosenWord = frames[0][DATA_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut   <= '0;
      wordValid <= 1'b0;
      frameErr  <= 1'b0;
      phaseSel  <= 2'd0;
    end else begin
      wordValid <= 1'b0;
      frameErr  <= 1'b0;
      if (strobes.decide) begin
        if (anyValid) begin
          wordValid <= 1'b1;
          wordOut   <= chosenWord;
          phaseSel  <= pickIdx;
        end else begin
          frameErr <= 1'b1;
        end
      end
    end
  end

  // R7: each strobe lasts exactly one cycle
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);
  // R6: a word and an error never appear together
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(wordValid && frameErr));
  // R5: the chosen phase always carries a good marker
  a_r5_pick_good: assert property (@(posedge clk) disable iff (!rstN)
    anyValid |-> hdrOk[pickIdx]);
  // R9: outputs hold between words
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> ($stable(wordOut) && $stable(phaseSel)));
endmodule

// File: rtl/capture_rx.sv
module capture_rx
  import capture_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HDR_W  = 3,
  parameter logic [HDR_W-1:0] HDR_PAT = 3'b010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              dataIn,
  output logic [DATA_W-1:0] wordOut,
  output logic              wordValid,
  output logic              frameErr,
  output logic [1:0]        phaseSel
);
  localparam int FRAME_LEN = HDR_W + DATA_W;

  capStrobes_t strobes;

  capture_ctl #(.FRAME_LEN(FRAME_LEN)) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .startIn(startIn),
    .strobes(strobes)
  );

  capture_dp #(.DATA_W(DATA_W), .HDR_W(HDR_W), .HDR_PAT(HDR_PAT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dataIn   (dataIn),
    .strobes  (strobes),
    .wordOut  (wordOut),
    .wordValid(wordValid),
    .frameErr (frameErr),
    .phaseSel (phaseSel)
  );
endmodule

// File: tb/sim_capture_rx.sv
module sim_capture_rx;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic        dataIn = 1'b0;
  logic [15:0] wordOut;
  logic        wordValid;
  logic        frameErr;
  logic [1:0]  phaseSel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  logic [18:0] frm [3];
  logic [15:0] lastWord = '0;
  logic [1:0]  lastSel = '0;

  capture_rx u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .dataIn(dataIn),
    .wordOut(wordOut), .wordValid(wordValid), .frameErr(frameErr), .phaseSel(phaseSel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    finished = 1;
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int expPick(logic [2:0] m);
    case (m)
      3'b111, 3'b011, 3'b010: return 1;
      3'b110, 3'b100:         return 2;
      3'b101, 3'b001:         return 0;
      default:                return -1;
    endcase
  endfunction

  // Drives one frame and checks the result window; midStart pulses startIn mid-frame.
  task automatic runFrame(bit midStart);
    logic [2:0] m;
    int pk;
    for (int p = 0; p < 3; p++) m[p] = (frm[p][18:16] == 3'b010); // R3
    pk = expPick(m);
    @(negedge clk); startIn = 1'b1;
    for (int k = 0; k < 57; k++) begin
      @(negedge clk);
      startIn = midStart && (k == 20 || k == 40);
      dataIn  = frm[k % 3][18 - k / 3];               // R2 sample order
    end
    @(negedge clk); startIn = 1'b0;
    check("R7 no early result", {30'd0, wordValid, frameErr}, 32'd0);
    @(negedge clk);
    if (pk >= 0) begin
      check("R7 word strobe", {30'd0, wordValid, frameErr}, 32'd2);
      check("R4 word value", {16'd0, wordOut}, {16'd0, frm[pk][15:0]});
      check("R5 chosen phase", {30'd0, phaseSel}, pk);
      lastWord = frm[pk][15:0];
      lastSel  = 2'(pk);
    end else begin
      check("R6 error strobe", {30'd0, wordValid, frameErr}, 32'd1);
      check("R6 R9 word held", {14'd0, phaseSel, wordOut}, {14'd0, lastSel, lastWord});
    end
    @(negedge clk);
    check("R7 strobe ends", {30'd0, wordValid, frameErr}, 32'd0);
    if (midStart) begin
      bit extra = 0;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (wordValid || frameErr) extra = 1;
      end
      check("R8 no extra result", {31'd0, extra}, 32'd0);
    end
  endtask

  function automatic logic [2:0] badHdr(int i);
    case (i % 4)
      0: return 3'b001;
      1: return 3'b100;
      2: return 3'b011;
      default: return 3'b000;
    endcase
  endfunction

  initial begin
    logic [15:0] w [3];
    void'($urandom(32'd4242));
    w[0] = 16'hA5C3; w[1] = 16'h1234; w[2] = 16'hFEDC;
    repeat (3) @(negedge clk);
    check("R1 reset strobes", {30'd0, wordValid, frameErr}, 32'd0);
    check("R1 reset word", {14'd0, phaseSel, wordOut}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R5 R6: every good/bad marker combination, distinct word per phase
    for (int m = 7; m >= 0; m--) begin
      for (int p = 0; p < 3; p++)
        frm[p] = {m[p] ? 3'b010 : badHdr(m + p), w[p]};
      runFrame(0);
    end

    // R4 boundary words on the middle phase
    for (int p = 0; p < 3; p++) frm[p] = {3'b010, 16'hFFFF};
    runFrame(0);
    for (int p = 0; p < 3; p++) frm[p] = {3'b010, 16'h0000};
    runFrame(0);

    // R8: start pulses during a frame
    for (int p = 0; p < 3; p++) frm[p] = {3'b010, w[p] ^ 16'h5A5A};
    runFrame(1);

    // Random frames, sometimes corrupted markers
    for (int i = 0; i < 300; i++) begin
      for (int p = 0; p < 3; p++) begin
        logic [2:0] h;
        h = ($urandom % 4 == 0) ? 3'($urandom) : 3'b010;
        frm[p] = {h, 16'($urandom)};
      end
      runFrame(i % 50 == 7);
      repeat ($urandom % 3) @(negedge clk);
    end
    summary();
  end
endmodule